// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Sequencer

This block holds the control state of eight DMA channels and services transfer requests that arrive from device-side engines. Each channel owns a block of four 32-bit words in a register window: a reserved word, a mode/flag word, a residual byte count and a start address. Software programs these words over a simple register bus. A device then asks for a transfer by naming a channel, a length and a direction.

For each request the block first clears the channel's three interrupt flags. It then checks the channel mode: the channel must be enabled, and its programmed direction must match the requested one. A request that fails this check is rejected. The block sets the channel's memory-error flag and a sticky per-channel bit in an error-source register, and issues no memory command. A request that passes is clamped to the residual count. The block then issues one memory burst command carrying the channel's start address and the clamped length. When the memory side takes the command, the block sets the terminal-count flag and lowers the count by the length moved. The start address is left as it was.

Requests and memory commands use valid/ready handshakes. A request is taken only while the block is idle, and one request is handled at a time: `req_ready` stays low from acceptance until the cycle after the done pulse. A command stays on the port, unchanged, for as long as `cmd_ready` is held low. A one-cycle done pulse reports the length moved and whether the request was rejected.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, every channel word and the error-source register read 0, `req_ready` is 1, and `cmd_valid` and `done_valid` are 0.
- R2: Word w (0..3) of channel c (0..7) is read and written at byte address 0x100 + 32*c + 8*w, and address bits [2:0] are ignored. All four words, the reserved word 0 included, read back the last value written, on all eight channels. Word 1 holds the flags, word 2 the count and word 3 the start address.
- R3: The error-source register is read at addresses 0x000 to 0x007, with bit c belonging to channel c. Bus writes to it have no effect, and its bits stay set until reset. Addresses outside this register and outside the channel window read 0.
- R4: When a request is accepted, flag bits 8 (terminal count), 9 (memory error) and 10 (address error) of that channel are cleared, whatever their earlier value.
- R5: A request is rejected when flag bit 0 (enable) is 0, or when `req_dir` (1 = device to memory, 0 = memory to device) equals flag bit 1 (0 = device to memory, 1 = memory to device). On a rejection, flag bit 9 is set, error-source bit c is set, no command is issued, and the done pulse carries `done_err`=1 and `done_len`=0.
- R6: An accepted request issues a command in the cycle after acceptance. The command length is the smaller of `req_len` and the channel's count word, the address is the channel's start word, and `cmd_to_mem` equals `req_dir`.
- R7: On the clock edge where the command is taken, flag bit 8 is set and the count word drops by the command length. The start address word is not changed.
- R8: `req_ready` is 1 only while no request is in progress. While `cmd_valid` is 1 and `cmd_ready` is 0, the command address, length and direction hold steady.
- R9: `done_valid` is high for exactly one cycle. That cycle follows the command handshake, or follows acceptance when the request is rejected, and `done_len` equals the length moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_chan | input | 2 | Requesting channel (channels 0..3) |
| req_len | input | 32 | Requested byte length |
| req_dir | input | 1 | 1 = device to memory, 0 = memory to device |
| cmd_valid | output | 1 | Memory burst command valid |
| cmd_ready | input | 1 | Memory side takes the command |
| cmd_addr | output | 32 | Burst start address |
| cmd_len | output | 32 | Burst byte length |
| cmd_to_mem | output | 1 | 1 = data goes into memory |
| done_valid | output | 1 | One-cycle completion pulse |
| done_len | output | 32 | Bytes moved |
| done_err | output | 1 | Request was rejected |

## Verification
The bench checks the length clamp on both sides of the count: a request shorter than the count, one longer than it, and one arriving when the count is already zero. It also checks that the count drops only by the clamped amount and that the start address never moves. A design that skipped the clamp, or advanced the address, would read back wrong register values. The bench loads all three interrupt flags before a request and sets stale flags before a rejected request. A design that cleared the flags only on success, or set the wrong flag, would be caught here. The bench also tests both rejection causes, a disabled channel and a direction mismatch, together with a write to the read-only error-source register. Finally, it stalls `cmd_ready` and drives a request into a busy block. A design that let the command change under stall, or accepted a second request early, would disagree with the per-cycle model.

// File: rtl/dma_pkg.sv
package dma_pkg;
  // flag word bit positions
  localparam int FLG_ENABLE   = 0;
  localparam int FLG_FROM_MEM = 1;
  localparam int FLG_TC       = 8;
  localparam int FLG_MERR     = 9;
  localparam int FLG_AERR     = 10;

  // word index inside a channel block
  localparam int WD_RSV   = 0;
  localparam int WD_FLAGS = 1;
  localparam int WD_COUNT = 2;
  localparam int WD_ADDR  = 3;
  localparam int NWORDS   = 4;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CMD  = 2'd1,
    SQ_DONE = 2'd2
  } sq_state_t;
endpackage

// File: rtl/dma_len_clamp.sv
module dma_len_clamp #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] want,
  input  logic [DW-1:0] avail,
  output logic [DW-1:0] len
);
  assign len = (want < avail) ? want : avail;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH   = 8,
  parameter int DW    = 32,
  parameter int ABITS = 10,
  localparam int CHW  = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [ABITS-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [CHW-1:0]   eng_chan,
  input  logic             eng_flags_we,
  input  logic [DW-1:0]    eng_flags_d,
  input  logic             eng_cnt_we,
  input  logic [DW-1:0]    eng_cnt_d,
  input  logic [NCH-1:0]   err_set,
  output logic [DW-1:0]    eng_flags,
  output logic [DW-1:0]    eng_cnt,
  output logic [DW-1:0]    eng_addr
);
  import dma_pkg::*;

  localparam int WIN_HI = ABITS - 8;

  logic [DW-1:0]  words [NCH][NWORDS];
  logic [NCH-1:0] err_q;

  logic           in_win;
  logic           in_err;
  logic [CHW-1:0] b_chan;
  logic [1:0]     b_word;
  logic [NCH-1:0][NWORDS-1:0] bus_we;

  assign in_win = (bus_addr[ABITS-1:8] == WIN_HI'(1));
  assign in_err = (bus_addr[ABITS-1:3] == '0);
  assign b_chan = bus_addr[5 +: CHW];
  assign b_word = bus_addr[4:3];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar w = 0; w < NWORDS; w++) begin : g_wd
      assign bus_we[c][w] = bus_sel && bus_wr && in_win &&
                            (b_chan == CHW'(c)) && (b_word == 2'(w));
    end
  end

  // engine update takes priority over a bus write in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int w = 0; w < NWORDS; w++)
          words[c][w] <= '0;
      err_q <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        for (int w = 0; w < NWORDS; w++) begin
          if (bus_we[c][w]) words[c][w] <= bus_wdata;
        end
        if (eng_flags_we && eng_chan == CHW'(c)) words[c][WD_FLAGS] <= eng_flags_d;
        if (eng_cnt_we && eng_chan == CHW'(c))   words[c][WD_COUNT] <= eng_cnt_d;
      end
      err_q <= err_q | err_set;
    end
  end

  assign eng_flags = words[eng_chan][WD_FLAGS];
  assign eng_cnt   = words[eng_chan][WD_COUNT];
  assign eng_addr  = words[eng_chan][WD_ADDR];

  always_comb begin
    if (in_win)      bus_rdata = words[b_chan][b_word];
    else if (in_err) bus_rdata = DW'(err_q);
    else             bus_rdata = '0;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_q & $past(err_q)) == $past(err_q)) || !$past(rst_n)); // R3
endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
  parameter int NCH  = 8,
  parameter int NREQ = 4,
  parameter int DW   = 32,
  localparam int CHW = $clog2(NCH),
  localparam int RQW = $clog2(NREQ)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [RQW-1:0] req_chan,
  input  logic [DW-1:0]  req_len,
  input  logic           req_dir,
  output logic           cmd_valid,
  input  logic           cmd_ready,
  output logic [DW-1:0]  cmd_addr,
  output logic [DW-1:0]  cmd_len,
  output logic           cmd_to_mem,
  output logic           done_valid,
  output logic [DW-1:0]  done_len,
  output logic           done_err,
  output logic [CHW-1:0] eng_chan,
  input  logic [DW-1:0]  eng_flags,
  input  logic [DW-1:0]  eng_cnt,
  input  logic [DW-1:0]  eng_addr,
  output logic           eng_flags_we,
  output logic [DW-1:0]  eng_flags_d,
  output logic           eng_cnt_we,
  output logic [DW-1:0]  eng_cnt_d,
  output logic [NCH-1:0] err_set
);
  import dma_pkg::*;

  localparam logic [DW-1:0] IRQ_MASK = (DW'(1) << FLG_TC) | (DW'(1) << FLG_MERR) |
                                       (DW'(1) << FLG_AERR);
  localparam logic [DW-1:0] TC_BIT   = DW'(1) << FLG_TC;
  localparam logic [DW-1:0] MERR_BIT = DW'(1) << FLG_MERR;

  sq_state_t      state_q;
  logic [CHW-1:0] chan_q;
  logic           dir_q;
  logic [DW-1:0]  len_q;
  logic [DW-1:0]  addr_q;
  logic           err_q;

  logic          accept, reject, cmd_fire;
  logic [DW-1:0] clamped;

  dma_len_clamp #(.DW(DW)) u_clamp (
    .want (req_len),
    .avail(eng_cnt),
    .len  (clamped)
  );

  assign eng_chan = (state_q == SQ_IDLE) ? CHW'(req_chan) : chan_q;
  assign accept   = req_valid && (state_q == SQ_IDLE);
  assign reject   = !eng_flags[FLG_ENABLE] || (req_dir == eng_flags[FLG_FROM_MEM]);
  assign cmd_fire = (state_q == SQ_CMD) && cmd_ready;

  always_comb begin
    eng_flags_we = accept || cmd_fire;
    eng_cnt_we   = cmd_fire;
    eng_cnt_d    = eng_cnt - len_q;
    err_set      = '0;
    if (accept) begin
      eng_flags_d = (eng_flags & ~IRQ_MASK) | (reject ? MERR_BIT : '0);
      if (reject) err_set = NCH'(1) << eng_chan;
    end else begin
      eng_flags_d = eng_flags | TC_BIT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      chan_q  <= '0;
      dir_q   <= 1'b0;
      len_q   <= '0;
      addr_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: if (accept) begin
          chan_q <= CHW'(req_chan);
          dir_q  <= req_dir;
          if (reject) begin
            err_q   <= 1'b1;
            len_q   <= '0;
            state_q <= SQ_DONE;
          end else begin
            err_q   <= 1'b0;
            len_q   <= clamped;
            addr_q  <= eng_addr;
            state_q <= SQ_CMD;
          end
        end
        SQ_CMD:  if (cmd_ready) state_q <= SQ_DONE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == SQ_IDLE);
  assign cmd_valid  = (state_q == SQ_CMD);
  assign cmd_addr   = addr_q;
  assign cmd_len    = len_q;
  assign cmd_to_mem = dir_q;
  assign done_valid = (state_q == SQ_DONE);
  assign done_len   = len_q;
  assign done_err   = err_q;

  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len) &&
    $stable(cmd_to_mem)); // R8
  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid && !done_valid); // R8
  AST_LEN_LE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_len <= eng_cnt); // R6
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R9
  AST_REJ_NOLEN: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_err |-> done_len == '0); // R5
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int NCH   = 8,
  parameter int NREQ  = 4,
  parameter int DW    = 32,
  parameter int ABITS = 10,
  localparam int CHW  = $clog2(NCH),
  localparam int RQW  = $clog2(NREQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [ABITS-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [RQW-1:0]   req_chan,
  input  logic [DW-1:0]    req_len,
  input  logic             req_dir,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [DW-1:0]    cmd_addr,
  output logic [DW-1:0]    cmd_len,
  output logic             cmd_to_mem,
  output logic             done_valid,
  output logic [DW-1:0]    done_len,
  output logic             done_err
);
  logic [CHW-1:0] eng_chan;
  logic [DW-1:0]  eng_flags, eng_cnt, eng_addr, eng_flags_d, eng_cnt_d;
  logic           eng_flags_we, eng_cnt_we;
  logic [NCH-1:0] err_set;

  dma_chan_regs #(.NCH(NCH), .DW(DW), .ABITS(ABITS)) u_regs (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .eng_chan, .eng_flags_we, .eng_flags_d, .eng_cnt_we, .eng_cnt_d,
    .err_set, .eng_flags, .eng_cnt, .eng_addr
  );

  dma_seq #(.NCH(NCH), .NREQ(NREQ), .DW(DW)) u_seq (
    .clk, .rst_n, .req_valid, .req_ready, .req_chan, .req_len, .req_dir,
    .cmd_valid, .cmd_ready, .cmd_addr, .cmd_len, .cmd_to_mem,
    .done_valid, .done_len, .done_err,
    .eng_chan, .eng_flags, .eng_cnt, .eng_addr,
    .eng_flags_we, .eng_flags_d, .eng_cnt_we, .eng_cnt_d, .err_set
  );
endmodule

// File: tb/sim_dma_chan_ctrl.sv
`timescale 1ns/1ps
module sim_dma_chan_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        req_valid = 0, req_ready, req_dir = 0;
  logic [1:0]  req_chan = '0;
  logic [31:0] req_len = '0;
  logic        cmd_valid, cmd_ready = 1, cmd_to_mem;
  logic [31:0] cmd_addr, cmd_len, done_len;
  logic        done_valid, done_err;

  always #2.5 clk = ~clk;

  dma_chan_ctrl u0 (.*);

  int nchk = 0, nerr = 0;
  bit run = 0;
  int stall = 0;

  // behavioural reference model
  logic [31:0] mw [8][4];
  logic [7:0]  merr;
  int          ph;
  int          mc;
  logic        mdir, mde;
  logic [31:0] mln, mca, mdl, f;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; merr = 0; mc = 0; mdir = 0; mde = 0; mln = 0; mca = 0; mdl = 0;
      for (int c = 0; c < 8; c++) for (int w = 0; w < 4; w++) mw[c][w] = 0;
    end else begin
      if (bus_sel && bus_wr && bus_addr[9:8] == 2'b01)
        mw[bus_addr[7:5]][bus_addr[4:3]] = bus_wdata;
      case (ph)
        0: if (req_valid) begin
          mc = int'(req_chan); mdir = req_dir;
          f = mw[mc][1] & ~32'h700;
          if (!f[0] || (req_dir == f[1])) begin
            f = f | 32'h200; merr[mc] = 1'b1; mde = 1; mdl = 0; ph = 2;
          end else begin
            mln = (req_len < mw[mc][2]) ? req_len : mw[mc][2];
            mca = mw[mc][3]; mde = 0; ph = 1;
          end
          mw[mc][1] = f;
        end
        1: if (cmd_ready) begin
          mw[mc][1] = mw[mc][1] | 32'h100;
          mw[mc][2] = mw[mc][2] - mln;
          mdl = mln; ph = 2;
        end
        default: ph = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // cmd_ready back-pressure driver
  always @(negedge clk) begin
    if (ph == 1 && stall > 0) begin cmd_ready <= 0; stall <= stall - 1; end
    else cmd_ready <= 1;
  end

  // per-cycle comparison
  always @(negedge clk) if (run) begin
    chk("R8 req_ready", 32'(req_ready), 32'(ph == 0));
    chk("R6 cmd_valid", 32'(cmd_valid), 32'(ph == 1));
    if (ph == 1) begin
      chk("R6 cmd_len", cmd_len, mln);
      chk("R6 cmd_addr", cmd_addr, mca);
      chk("R6 cmd_to_mem", 32'(cmd_to_mem), 32'(mdir));
    end
    chk("R9 done_valid", 32'(done_valid), 32'(ph == 2));
    if (ph == 2) begin
      chk("R9 done_len", done_len, mdl);
      chk("R5 done_err", 32'(done_err), 32'(mde));
    end
  end

  function automatic logic [31:0] exp_rd(input logic [9:0] a);
    if (a[9:8] == 2'b01) return mw[a[7:5]][a[4:3]];
    if (a[9:3] == 0) return 32'(merr);
    return 0;
  endfunction

  function automatic logic [9:0] ra(input int c, input int w);
    return 10'(32'h100 + c * 32 + w * 8);
  endfunction

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [9:0] a);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp_rd(a));
    bus_sel = 0;
    @(negedge clk);
  endtask

  task automatic rq(input int ch, input int len, input bit dir, input int st, input bit wait_done);
    stall = st;
    req_valid = 1; req_chan = 2'(ch); req_len = 32'(len); req_dir = dir;
    while (ph != 0) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (wait_done) while (ph != 0) @(negedge clk);
  endtask

  initial begin
    #900000;
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    run = 1;
    // R1 reset state
    chk("R1 req_ready", 32'(req_ready), 1);
    for (int c = 0; c < 8; c++) for (int w = 0; w < 4; w++) rd("R1 reg", ra(c, w));
    rd("R1 errsrc", 10'h000);
    // programming
    wr(ra(0,1), 32'h1); wr(ra(0,2), 100); wr(ra(0,3), 32'h1000);
    wr(ra(1,1), 32'h703); wr(ra(1,2), 16); wr(ra(1,3), 32'h2000_0040);
    wr(ra(2,1), 32'h0); wr(ra(2,2), 64);
    wr(ra(3,1), 32'h1); wr(ra(3,2), 8);
    for (int c = 4; c < 8; c++) for (int w = 0; w < 4; w++)
      wr(ra(c, w), 32'hA500_0000 + 32'(c * 16 + w));
    wr(ra(0,0), 32'hDEAD_BEEF);
    for (int c = 0; c < 8; c++) for (int w = 0; w < 4; w++) rd("R2 readback", ra(c, w));
    rd("R2 low bits ignored", ra(5,3) + 10'd5);
    rd("R2 low bits ignored", ra(1,1) + 10'd7);
    // normal transfer shorter than count
    rq(0, 40, 1, 0, 1);
    rd("R7 flags tc", ra(0,1)); rd("R7 count", ra(0,2)); rd("R7 addr fixed", ra(0,3));
    // clamp to residual count, with stall
    rq(0, 100, 1, 2, 1);
    rd("R6 clamp count", ra(0,2)); rd("R7 addr fixed", ra(0,3));
    // count already zero
    rq(0, 5, 1, 0, 1);
    rd("R6 zero count", ra(0,2));
    // stale interrupt flags cleared, memory-to-device, longer stall
    rq(1, 8, 0, 3, 1);
    rd("R4 flags", ra(1,1)); rd("R7 count", ra(1,2));
    // disabled channel rejected
    rq(2, 4, 1, 0, 1);
    rd("R5 flags", ra(2,1)); rd("R5 count kept", ra(2,2)); rd("R3 errsrc", 10'h000);
    // direction mismatch rejected
    rq(3, 4, 0, 0, 1);
    rd("R5 flags", ra(3,1)); rd("R3 errsrc", 10'h004);
    // error source read-only and sticky
    wr(10'h000, 32'h0); rd("R3 errsrc ro", 10'h000);
    rd("R3 unmapped", 10'h200); rd("R3 unmapped", 10'h080); rd("R3 unmapped", 10'h008);
    // back-to-back: second request waits for the first
    wr(ra(0,2), 50);
    rq(0, 10, 1, 1, 0);
    rq(1, 4, 0, 0, 1);
    rd("R7 count", ra(0,2)); rd("R7 count", ra(1,2));
    // reject clears stale tc flag
    rq(0, 4, 0, 0, 1);
    rd("R4 flags reject", ra(0,1)); rd("R3 errsrc", 10'h000);
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule